// File: doc/BRIEF.md
# Two-Bank Open-Row Memory Access Sequencer

This block takes memory access requests, each naming a column, a row and one of two banks, and plays out the timing that an open-row memory would need to serve them. Each bank keeps the row of the request it accepted most recently. A request that lands on that same row goes straight to a column access. A request for any other row first closes the old row with a precharge, then opens the new one with a row access, and only then does the column access.

The two banks step through their sequences independently and may be busy at the same time. They share one column stage, so their column accesses are serialized by a small arbiter that favours the bank it did not grant last. A request is acknowledged in the cycle its target bank takes it on. A registered completion pulse reports the bank and column of each finished access. The block is meant to stand in a performance model or a memory front end. It gives realistic, history-dependent latencies and bank conflicts. It stores no data.

Top module: `openrow_seq_top`

## Requirements
- R1: A request carries `req_col`, `req_row` and `req_bank`, where `req_bank` = 0 selects bank 0 and 1 selects bank 1. The column of an accepted request is reported on `done_col` when that request completes.
- R2: If a request misses, meaning its row differs from the open row of its bank, `done_valid` rises exactly 8 cycles after the acknowledge cycle when there is no column contention. That is 3 cycles of precharge, 3 of row access, 1 of column access and 1 output register stage.
- R3: If a request hits, meaning its row equals the open row of its bank, `done_valid` rises exactly 2 cycles after the acknowledge cycle when there is no column contention.
- R4: After reset neither bank has an open row. The first request to each bank is therefore a miss, even when its row is 0.
- R5: Column accesses of the two banks never overlap. When both banks are ready for the column stage in the same cycle, the losing bank completes one cycle after the winner.
- R6: `req_ack` is high in a cycle exactly when `req_valid` is high and the addressed bank is idle. A bank is busy from the cycle after acceptance until the cycle its completion pulse appears. A new request to that bank can be acknowledged in that same cycle.
- R7: `done_valid` is a one-cycle pulse per completed request. In that cycle `done_bank` gives the bank.
- R8: On a column conflict, the bank that was not the most recent column winner is granted. After reset, bank 0 wins the first conflict.
- R9: A bank's open row is updated only when that bank accepts a request. Requests to one bank never change the other bank's open row, and the two banks may be busy concurrently.
- R10: After reset, with no request present, `req_ack` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_col | input | COL_W | Column index of the request |
| req_row | input | ROW_W | Row index of the request |
| req_bank | input | 1 | Target bank |
| req_ack | output | 1 | Request taken this cycle |
| done_valid | output | 1 | One-cycle completion pulse |
| done_bank | output | 1 | Bank of the completed request |
| done_col | output | COL_W | Column of the completed request |

## Verification
The bench builds the block with a 4-bit row and a 3-bit column and keeps the timing at 3/3/1 cycles. With these values, row 0 can be used to show that reset leaves no row open, and the hit and miss latencies can be checked as exact cycle counts. A stimulus table alternates banks and rows so that hits and misses occur on both banks. Directed sequences then time a hit on one bank so that its column request coincides with the end of a miss on the other bank. They do this once with each bank holding last-winner priority, which exercises both arbitration outcomes and the one-cycle penalty for the loser.

// File: rtl/openrow_seq_pkg.sv
package openrow_seq_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_PRE,
    BS_ACT,
    BS_CREQ,
    BS_COL
  } bank_state_t;
endpackage

// File: rtl/openrow_col_arb.sv
module openrow_col_arb
  import openrow_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] req,
  input  logic                 busy,
  output logic [NUM_BANKS-1:0] gnt
);
  logic last_q;

  always_comb begin
    gnt = '0;
    if (!busy) begin
      if (req == 2'b11) gnt[~last_q] = 1'b1;
      else              gnt = req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b1;
    else if (|gnt) last_q <= gnt[1];
  end

  assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_gnt_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);
  assert_tie_alternates_R8: assert property (@(posedge clk) disable iff (rst)
    (req == 2'b11 && !busy) |=> (last_q != $past(last_q)));
endmodule

// File: rtl/openrow_bank_seq.sv
module openrow_bank_seq
  import openrow_seq_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 6,
  parameter int PRE_CYC = 3,
  parameter int ACT_CYC = 3,
  parameter int COL_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [ROW_W-1:0] acc_row,
  input  logic [COL_W-1:0] acc_col,
  input  logic             col_gnt,
  output logic             idle,
  output logic             col_req,
  output logic             col_hold,
  output logic             col_active,
  output logic             col_done,
  output logic [COL_W-1:0] cur_col
);
  localparam int MAX_A    = (PRE_CYC > ACT_CYC) ? PRE_CYC : ACT_CYC;
  localparam int MAX_C    = (MAX_A > COL_CYC) ? MAX_A : COL_CYC;
  localparam int CNT_W    = $clog2(MAX_C + 1);
  localparam int COL_LOAD = (COL_CYC > 1) ? COL_CYC - 2 : 0;

  bank_state_t      st;
  logic [CNT_W-1:0] cnt;
  logic [ROW_W-1:0] row_q;
  logic             row_vld;
  logic             hit;

  assign hit        = row_vld && (row_q == acc_row);
  assign idle       = (st == BS_IDLE);
  assign col_req    = (st == BS_CREQ);
  assign col_hold   = (st == BS_COL);
  assign col_active = (col_req && col_gnt) || col_hold;
  assign col_done   = (col_req && col_gnt && COL_CYC == 1) ||
                      (col_hold && cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= BS_IDLE;
      cnt     <= '0;
      row_q   <= '0;
      row_vld <= 1'b0;
      cur_col <= '0;
    end else begin
      case (st)
        BS_IDLE: if (accept) begin
          row_q   <= acc_row;
          row_vld <= 1'b1;
          cur_col <= acc_col;
          if (hit) st <= BS_CREQ;
          else begin
            st  <= BS_PRE;
            cnt <= CNT_W'(PRE_CYC - 1);
          end
        end
        BS_PRE: if (cnt == '0) begin
          st  <= BS_ACT;
          cnt <= CNT_W'(ACT_CYC - 1);
        end else cnt <= cnt - 1'b1;
        BS_ACT: if (cnt == '0) st <= BS_CREQ;
                else cnt <= cnt - 1'b1;
        BS_CREQ: if (col_gnt) begin
          if (COL_CYC == 1) st <= BS_IDLE;
          else begin
            st  <= BS_COL;
            cnt <= CNT_W'(COL_LOAD);
          end
        end
        BS_COL: if (cnt == '0) st <= BS_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= BS_IDLE;
      endcase
    end
  end

  assert_hit_to_column_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> (st == BS_CREQ));
  assert_miss_to_precharge_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (st == BS_PRE));
  assert_row_update_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (row_vld && row_q == $past(acc_row)));
  assert_row_kept_R9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(row_q));
endmodule

// File: rtl/openrow_seq_top.sv
module openrow_seq_top
  import openrow_seq_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 6,
  parameter int PRE_CYC = 3,
  parameter int ACT_CYC = 3,
  parameter int COL_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_bank,
  output logic             req_ack,
  output logic             done_valid,
  output logic             done_bank,
  output logic [COL_W-1:0] done_col
);
  logic [NUM_BANKS-1:0] idle_vec, creq_vec, hold_vec, act_vec, cdone_vec, gnt_vec;
  logic [COL_W-1:0]     cur_col [NUM_BANKS];

  assign req_ack = req_valid && idle_vec[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    openrow_bank_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W),
      .PRE_CYC(PRE_CYC), .ACT_CYC(ACT_CYC), .COL_CYC(COL_CYC)
    ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .accept    (req_ack && (req_bank == 1'(b))),
      .acc_row   (req_row),
      .acc_col   (req_col),
      .col_gnt   (gnt_vec[b]),
      .idle      (idle_vec[b]),
      .col_req   (creq_vec[b]),
      .col_hold  (hold_vec[b]),
      .col_active(act_vec[b]),
      .col_done  (cdone_vec[b]),
      .cur_col   (cur_col[b])
    );
  end

  openrow_col_arb u_arb (
    .clk (clk),
    .rst (rst),
    .req (creq_vec),
    .busy(|hold_vec),
    .gnt (gnt_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_bank  <= 1'b0;
      done_col   <= '0;
    end else begin
      done_valid <= |cdone_vec;
      done_bank  <= cdone_vec[1];
      done_col   <= cdone_vec[1] ? cur_col[1] : cur_col[0];
    end
  end

  assert_col_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(act_vec));
  assert_ack_makes_busy_R6: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !idle_vec[$past(req_bank)]);
  assert_done_follows_col_R7: assert property (@(posedge clk) disable iff (rst)
    (|cdone_vec) |=> done_valid);
  assert_done_needs_col_R7: assert property (@(posedge clk) disable iff (rst)
    !(|cdone_vec) |=> !done_valid);
endmodule

// File: tb/openrow_seq_top_test.sv
`timescale 1ns/100ps
module openrow_seq_top_test;
  localparam int RW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_col = '0;
  logic [RW-1:0] req_row = '0;
  logic          req_bank = 1'b0;
  logic          req_ack, done_valid, done_bank;
  logic [CW-1:0] done_col;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_at [2];
  int dcol_at [2];

  always #2.5 clk = ~clk;

  openrow_seq_top #(.ROW_W(RW), .COL_W(CW), .PRE_CYC(3), .ACT_CYC(3), .COL_CYC(1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_col(req_col),
    .req_row(req_row), .req_bank(req_bank), .req_ack(req_ack),
    .done_valid(done_valid), .done_bank(done_bank), .done_col(done_col)
  );

  // {bank, row, col, latency}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 4'd0, 3'd1, 4'd8},  // R4: first bank0 access, row 0, miss
    {1'b0, 4'd0, 3'd2, 4'd2},  // R3: hit
    {1'b0, 4'd7, 3'd3, 4'd8},  // R2: miss
    {1'b1, 4'd7, 3'd4, 4'd8},  // R4/R9: bank1 first access misses
    {1'b1, 4'd7, 3'd5, 4'd2},  // R3
    {1'b0, 4'd7, 3'd6, 4'd2},  // R9: bank0 row untouched by bank1
    {1'b0, 4'd0, 3'd7, 4'd8},  // R2
    {1'b1, 4'd0, 3'd0, 4'd8}   // R2
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual cycle %0d expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (done_valid) begin
      done_at[done_bank] = cyc;
      dcol_at[done_bank] = int'(done_col);
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_cycle(input int n);
    while (cyc < n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic issue(input logic b, input logic [RW-1:0] r, input logic [CW-1:0] c,
                       output int t_ack);
    req_bank  = b;
    req_row   = r;
    req_col   = c;
    req_valid = 1'b1;
    #1;
    while (!req_ack) begin
      @(negedge clk);
      #1;
    end
    t_ack = cyc;
    @(negedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic clear_done();
    done_at[0] = -1;
    done_at[1] = -1;
  endtask

  initial begin
    int t, t2;
    clear_done();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    check(req_ack == 1'b0, "R10 ack idle", int'(req_ack), 0);
    check(done_valid == 1'b0, "R10 done idle", int'(done_valid), 0);

    // Table walk: R1 R2 R3 R4 R7 R9
    for (int i = 0; i < 8; i++) begin
      logic          vb;
      logic [RW-1:0] vr;
      logic [CW-1:0] vc;
      int            vl;
      vb = VEC[i][11];
      vr = VEC[i][10:7];
      vc = VEC[i][6:4];
      vl = int'(VEC[i][3:0]);
      clear_done();
      issue(vb, vr, vc, t);
      wait_cycle(t + vl);
      check(done_at[vb] == t + vl, (vl == 8) ? "R2 miss latency" : "R3 hit latency",
            done_at[vb] - t, vl);
      check(dcol_at[vb] == int'(vc), "R1 done column", dcol_at[vb], int'(vc));
      wait_cycle(t + vl + 1);
      check(done_valid == 1'b0, "R7 single-cycle pulse", int'(done_valid), 0);
    end

    // R6: busy bank delays acknowledge until its completion cycle
    clear_done();
    issue(1'b0, 4'd6, 3'd1, t);
    req_bank = 1'b0; req_row = 4'd6; req_col = 3'd2; req_valid = 1'b1;
    #1;
    check(req_ack == 1'b0, "R6 ack held while busy", int'(req_ack), 0);
    wait_cycle(t + 7);
    check(req_ack == 1'b0, "R6 ack held late", int'(req_ack), 0);
    wait_cycle(t + 8);
    check(req_ack == 1'b1, "R6 ack on idle", int'(req_ack), 1);
    check(done_valid && done_bank == 1'b0, "R7 done bank", int'(done_bank), 0);
    @(negedge clk);
    #1;
    req_valid = 1'b0;
    wait_cycle(t + 10);
    check(done_at[0] == t + 10, "R3 hit after wait", done_at[0] - t, 10);

    // R5/R8: conflict with bank0 as last winner -> bank1 wins
    clear_done();
    issue(1'b1, 4'd3, 3'd3, t);
    wait_cycle(t + 6);
    issue(1'b0, 4'd6, 3'd4, t2);
    check(t2 == t + 6, "R9 concurrent bank accept", t2 - t, 6);
    wait_cycle(t + 9);
    check(done_at[1] == t + 8, "R8 bank1 wins", done_at[1] - t, 8);
    check(done_at[0] == t + 9, "R5 bank0 delayed", done_at[0] - t, 9);
    check(dcol_at[0] == 4, "R1 conflict column", dcol_at[0], 4);

    // make bank1 the last winner
    clear_done();
    issue(1'b1, 4'd3, 3'd5, t);
    wait_cycle(t + 2);
    check(done_at[1] == t + 2, "R3 bank1 hit", done_at[1] - t, 2);

    // R5/R8: conflict with bank1 as last winner -> bank0 wins
    clear_done();
    issue(1'b1, 4'd4, 3'd6, t);
    wait_cycle(t + 6);
    issue(1'b0, 4'd6, 3'd7, t2);
    wait_cycle(t + 9);
    check(done_at[0] == t + 8, "R8 bank0 wins", done_at[0] - t, 8);
    check(done_at[1] == t + 9, "R5 bank1 delayed", done_at[1] - t, 9);
    check(dcol_at[1] == 6, "R1 delayed column", dcol_at[1], 6);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule